// File: doc/BRIEF.md
# Virtqueue Descriptor Chain Fetcher

This block takes one request out of a split virtqueue that lives in system memory. From a page frame number and a power-of-two queue size it derives where the descriptor table, the available ring and the used ring sit. On a start pulse it reads the available ring's index field to see whether the driver has posted anything new. If it has, the block reads the next head index from the available ring and follows the linked descriptors. It sorts every descriptor into one of two lists of address and length pairs: one for buffers the device may write and one for buffers the device reads.

The block keeps its own next-available counter. It reaches memory through a simple port: a held request paired with a one-cycle response that carries eight bytes. When the walk finishes it raises a one-cycle done strobe. At that point the head index, both segment lists, their counts and two status bits (queue empty, chain too long) are valid. They stay valid until the next start. A chain that never ends, for example one that points back to itself, is cut off at a parameterised segment limit.

The state machine has six states. ST_IDLE waits for start. ST_AVAIL_IDX reads the available index. It goes to ST_FINISH if the queue is empty and to ST_HEAD if it is not. ST_HEAD reads the head entry. ST_DESC_LO reads a descriptor's address word, then ST_DESC_HI reads its length, flags and next word. From ST_DESC_HI the machine returns to ST_DESC_LO to follow the chain, or goes to ST_FINISH at the end of the chain or at the segment limit. ST_FINISH raises done for one cycle and returns to ST_IDLE.

Top module: `vq_chain_fetch`

## Requirements
- R1: desc_base equals pfn shifted left by 12 bits.
- R2: avail_base equals desc_base + 16 * Q, where Q = 2**qsize_log2.
- R3: used_base equals avail_base + 4 + 2*Q rounded up to the next multiple of 4096.
- R4: A start in ST_IDLE first reads the 16-bit available index at avail_base+2. If that index equals the internal next-available counter, done rises with empty=1, err=0 and both counts zero, and the counter does not change.
- R5: Otherwise the block reads the head from avail_base + 4 + 2*(counter mod Q). head_idx is that value mod Q, and the counter then increments by one, so consecutive requests wrap around the ring.
- R6: Descriptor k is read as two 8-byte words: the address at desc_base+16*(k mod Q), then a second word at +8 holding the length in bits 31:0, the flags in bits 47:32 and the next index in bits 63:48.
- R7: A descriptor whose flag bit 1 (device-writes) is set is appended to the in list. Any other descriptor is appended to the out list. Each list keeps chain order, and in_cnt and out_cnt count its entries.
- R8: While flag bit 0 (chain continues) is set, the walk goes on at the next index mod Q. Otherwise it ends, and done is high for exactly one cycle.
- R9: If a chain would need more than MAX_SEGS segments, the walk stops after MAX_SEGS of them with err=1, and in_cnt+out_cnt equals MAX_SEGS.
- R10: mem_req stays high with a stable mem_addr until mem_rsp_valid. mem_rsp_data holds the eight bytes starting at mem_addr, little-endian.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one fetch; honoured only when idle |
| pfn | input | PFN_W | Page frame number of the descriptor table |
| qsize_log2 | input | QLOG_W | Log2 of the queue size |
| desc_base | output | ADDR_W | Descriptor table address |
| avail_base | output | ADDR_W | Available ring address |
| used_base | output | ADDR_W | Used ring address |
| mem_req | output | 1 | Read request, held until response |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 64 | Eight bytes from mem_addr, little-endian |
| done | output | 1 | One-cycle fetch-complete strobe |
| empty | output | 1 | The fetch found no posted request |
| err | output | 1 | The chain was cut at the segment limit |
| head_idx | output | 16 | Head descriptor index of the request |
| in_cnt | output | clog2(MAX_SEGS+1) | Entries in the device-writable list |
| out_cnt | output | clog2(MAX_SEGS+1) | Entries in the device-readable list |
| in_addr | output | MAX_SEGS*ADDR_W | Device-writable segment addresses |
| in_len | output | MAX_SEGS*32 | Device-writable segment lengths |
| out_addr | output | MAX_SEGS*ADDR_W | Device-readable segment addresses |
| out_len | output | MAX_SEGS*32 | Device-readable segment lengths |

## Verification
The hardest case to reach from the ports is a chain that loops back on itself. It has to be combined with a ring slot the counter only reaches after it has gone past the queue size. The stimulus first posts and drains one request from every slot of a four-entry ring. It then rewrites slot zero to point at a self-linked descriptor, so the fifth fetch checks wraparound and the segment-limit stop together. Other fetches use next and head values at or above the queue size to check the index masking, and the memory model's latency depends on address bit 3 to vary how long each request is held.

// File: rtl/vqf_pkg.sv
package vqf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AVAIL_IDX,
        ST_HEAD,
        ST_DESC_LO,
        ST_DESC_HI,
        ST_FINISH
    } fetch_state_t;

    localparam int PAGE_SHIFT     = 12;
    localparam int AVAIL_IDX_OFS  = 2;
    localparam int AVAIL_RING_OFS = 4;
    localparam int DESC_HI_OFS    = 8;
    localparam int FLAG_CHAIN_BIT = 0;
    localparam int FLAG_DEVWR_BIT = 1;
endpackage

// File: rtl/vqf_ring_addr.sv
module vqf_ring_addr
    import vqf_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PFN_W  = 32,
    parameter int QLOG_W = 4
) (
    input  logic [PFN_W-1:0]  pfn,
    input  logic [QLOG_W-1:0] qsize_log2,
    output logic [ADDR_W-1:0] desc_base,
    output logic [ADDR_W-1:0] avail_base,
    output logic [ADDR_W-1:0] used_base,
    output logic [15:0]       idx_mask
);
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PAGE_LOW = (ONE << PAGE_SHIFT) - ONE;

    logic [ADDR_W-1:0] qsz;
    logic [ADDR_W-1:0] avail_end;

    always_comb begin
        qsz        = ONE << qsize_log2;
        desc_base  = ADDR_W'(pfn) << PAGE_SHIFT;
        avail_base = desc_base + (qsz << 4);
        avail_end  = avail_base + ADDR_W'(AVAIL_RING_OFS) + (qsz << 1);
        used_base  = (avail_end + PAGE_LOW) & ~PAGE_LOW;
        idx_mask   = 16'(qsz - ONE);
    end
endmodule

// File: rtl/vqf_seg_store.sv
module vqf_seg_store #(
    parameter int ADDR_W   = 64,
    parameter int LEN_W    = 32,
    parameter int MAX_SEGS = 4,
    localparam int CNT_W   = $clog2(MAX_SEGS + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear,
    input  logic                             push,
    input  logic                             is_write,
    input  logic [ADDR_W-1:0]                seg_addr,
    input  logic [LEN_W-1:0]                 seg_len,
    output logic [CNT_W-1:0]                 in_cnt,
    output logic [CNT_W-1:0]                 out_cnt,
    output logic [MAX_SEGS-1:0][ADDR_W-1:0]  in_addr,
    output logic [MAX_SEGS-1:0][LEN_W-1:0]   in_len,
    output logic [MAX_SEGS-1:0][ADDR_W-1:0]  out_addr,
    output logic [MAX_SEGS-1:0][LEN_W-1:0]   out_len
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            in_cnt  <= '0;
            out_cnt <= '0;
        end else if (push) begin
            if (is_write) in_cnt  <= in_cnt + 1'b1;
            else          out_cnt <= out_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_addr  <= '0;
            in_len   <= '0;
            out_addr <= '0;
            out_len  <= '0;
        end else if (push) begin
            for (int i = 0; i < MAX_SEGS; i++) begin
                if (is_write && in_cnt == CNT_W'(i)) begin
                    in_addr[i] <= seg_addr;
                    in_len[i]  <= seg_len;
                end
                if (!is_write && out_cnt == CNT_W'(i)) begin
                    out_addr[i] <= seg_addr;
                    out_len[i]  <= seg_len;
                end
            end
        end
    end

    AST_SEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, in_cnt} + {1'b0, out_cnt}) <= (CNT_W+1)'(MAX_SEGS)); // R9
endmodule

// File: rtl/vq_chain_fetch.sv
module vq_chain_fetch
    import vqf_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int PFN_W    = 32,
    parameter int QLOG_W   = 4,
    parameter int MAX_SEGS = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic [PFN_W-1:0]                      pfn,
    input  logic [QLOG_W-1:0]                     qsize_log2,
    output logic [ADDR_W-1:0]                     desc_base,
    output logic [ADDR_W-1:0]                     avail_base,
    output logic [ADDR_W-1:0]                     used_base,
    output logic                                  mem_req,
    output logic [ADDR_W-1:0]                     mem_addr,
    input  logic                                  mem_rsp_valid,
    input  logic [63:0]                           mem_rsp_data,
    output logic                                  done,
    output logic                                  empty,
    output logic                                  err,
    output logic [15:0]                           head_idx,
    output logic [$clog2(MAX_SEGS+1)-1:0]         in_cnt,
    output logic [$clog2(MAX_SEGS+1)-1:0]         out_cnt,
    output logic [MAX_SEGS-1:0][ADDR_W-1:0]       in_addr,
    output logic [MAX_SEGS-1:0][31:0]             in_len,
    output logic [MAX_SEGS-1:0][ADDR_W-1:0]       out_addr,
    output logic [MAX_SEGS-1:0][31:0]             out_len
);
    localparam int CNT_W = $clog2(MAX_SEGS + 1);

    fetch_state_t       state, state_nx;
    logic [15:0]        idx_mask;
    logic [15:0]        next_avail;
    logic [15:0]        cur_idx;
    logic [ADDR_W-1:0]  seg_addr_q;
    logic [CNT_W:0]     total;
    logic               chain_more;
    logic               at_limit;
    logic               seg_push;
    logic               clear_lists;
    logic               unused_flag_bits;

    vqf_ring_addr #(.ADDR_W(ADDR_W), .PFN_W(PFN_W), .QLOG_W(QLOG_W)) u_addr (
        .pfn        (pfn),
        .qsize_log2 (qsize_log2),
        .desc_base  (desc_base),
        .avail_base (avail_base),
        .used_base  (used_base),
        .idx_mask   (idx_mask)
    );

    assign total            = {1'b0, in_cnt} + {1'b0, out_cnt};
    assign chain_more       = mem_rsp_data[32 + FLAG_CHAIN_BIT];
    assign at_limit         = (total + 1'b1) == (CNT_W+1)'(MAX_SEGS);
    assign seg_push         = (state == ST_DESC_HI) && mem_rsp_valid;
    assign clear_lists      = (state == ST_IDLE) && start;
    assign unused_flag_bits = ^mem_rsp_data[47:34];

    vqf_seg_store #(.ADDR_W(ADDR_W), .LEN_W(32), .MAX_SEGS(MAX_SEGS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_lists),
        .push     (seg_push),
        .is_write (mem_rsp_data[32 + FLAG_DEVWR_BIT]),
        .seg_addr (seg_addr_q),
        .seg_len  (mem_rsp_data[31:0]),
        .in_cnt   (in_cnt),
        .out_cnt  (out_cnt),
        .in_addr  (in_addr),
        .in_len   (in_len),
        .out_addr (out_addr),
        .out_len  (out_len)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_AVAIL_IDX;
            ST_AVAIL_IDX: if (mem_rsp_valid)
                              state_nx = (mem_rsp_data[15:0] == next_avail) ? ST_FINISH : ST_HEAD;
            ST_HEAD:      if (mem_rsp_valid) state_nx = ST_DESC_LO;
            ST_DESC_LO:   if (mem_rsp_valid) state_nx = ST_DESC_HI;
            ST_DESC_HI:   if (mem_rsp_valid)
                              state_nx = (chain_more && !at_limit) ? ST_DESC_LO : ST_FINISH;
            ST_FINISH:    state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        done     = 1'b0;
        unique case (state)
            ST_AVAIL_IDX: begin
                mem_req  = 1'b1;
                mem_addr = avail_base + ADDR_W'(AVAIL_IDX_OFS);
            end
            ST_HEAD: begin
                mem_req  = 1'b1;
                mem_addr = avail_base + ADDR_W'(AVAIL_RING_OFS)
                         + ADDR_W'({next_avail & idx_mask, 1'b0});
            end
            ST_DESC_LO: begin
                mem_req  = 1'b1;
                mem_addr = desc_base + ADDR_W'({cur_idx, 4'b0000});
            end
            ST_DESC_HI: begin
                mem_req  = 1'b1;
                mem_addr = desc_base + ADDR_W'({cur_idx, 4'b0000}) + ADDR_W'(DESC_HI_OFS);
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_avail <= '0;
            cur_idx    <= '0;
            head_idx   <= '0;
            seg_addr_q <= '0;
            empty      <= 1'b0;
            err        <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    empty <= 1'b0;
                    err   <= 1'b0;
                end
                ST_AVAIL_IDX: if (mem_rsp_valid && mem_rsp_data[15:0] == next_avail)
                    empty <= 1'b1;
                ST_HEAD: if (mem_rsp_valid) begin
                    head_idx   <= mem_rsp_data[15:0] & idx_mask;
                    cur_idx    <= mem_rsp_data[15:0] & idx_mask;
                    next_avail <= next_avail + 16'd1;
                end
                ST_DESC_LO: if (mem_rsp_valid) seg_addr_q <= mem_rsp_data[ADDR_W-1:0];
                ST_DESC_HI: if (mem_rsp_valid && chain_more) begin
                    if (at_limit) err     <= 1'b1;
                    else          cur_idx <= mem_rsp_data[63:48] & idx_mask;
                end
                default: ;
            endcase
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && empty) |-> (in_cnt == '0 && out_cnt == '0 && !err)); // R4
    AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (total == (CNT_W+1)'(MAX_SEGS))); // R9
    AST_HEAD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !empty) |-> ((head_idx & ~idx_mask) == 16'd0)); // R5
endmodule

// File: tb/vq_chain_fetch_bench.sv
`timescale 1ns/1ps
module vq_chain_fetch_bench;
    localparam int NS = 4;
    localparam logic [63:0] DBASE = 64'h5000;
    localparam logic [63:0] ABASE = 64'h5040;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] pfn = 32'd5;
    logic [3:0]  qsize_log2 = 4'd2;
    logic [63:0] desc_base, avail_base, used_base, mem_addr;
    logic mem_req, mem_rsp_valid, done, empty, err;
    logic [63:0] mem_rsp_data;
    logic [15:0] head_idx;
    logic [2:0]  in_cnt, out_cnt;
    logic [NS-1:0][63:0] in_addr, out_addr;
    logic [NS-1:0][31:0] in_len, out_len;

    always #4 clk = ~clk;

    vq_chain_fetch u_vq_chain_fetch (
        .clk(clk), .rst_n(rst_n), .start(start), .pfn(pfn), .qsize_log2(qsize_log2),
        .desc_base(desc_base), .avail_base(avail_base), .used_base(used_base),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .empty(empty), .err(err),
        .head_idx(head_idx), .in_cnt(in_cnt), .out_cnt(out_cnt),
        .in_addr(in_addr), .in_len(in_len), .out_addr(out_addr), .out_len(out_len)
    );

    typedef struct packed {
        bit              empty;
        bit              err;
        bit [15:0]       head;
        bit [2:0]        in_cnt;
        bit [2:0]        out_cnt;
        bit [NS-1:0][63:0] in_addr;
        bit [NS-1:0][31:0] in_len;
        bit [NS-1:0][63:0] out_addr;
        bit [NS-1:0][31:0] out_len;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0, seen = 0, target = 0;
    bit finished = 0;

    bit [7:0]  mem [bit [63:0]];
    bit [63:0] d_addr [NS];
    bit [31:0] d_len  [NS];
    bit [15:0] d_flags[NS];
    bit [15:0] d_next [NS];
    bit [15:0] ring   [NS];
    bit [15:0] aidx_m = 0;
    bit [15:0] nav = 0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    task automatic wr(bit [63:0] a, bit [63:0] v, int nbytes);
        for (int b = 0; b < nbytes; b++) mem[a + 64'(b)] = v[8*b +: 8];
    endtask

    function automatic bit [63:0] rd64(bit [63:0] a);
        bit [63:0] r = '0;
        for (int b = 0; b < 8; b++)
            if (mem.exists(a + 64'(b))) r[8*b +: 8] = mem[a + 64'(b)];
        return r;
    endfunction

    task automatic set_desc(int i, bit [63:0] a, bit [31:0] l, bit [15:0] f, bit [15:0] n);
        d_addr[i] = a; d_len[i] = l; d_flags[i] = f; d_next[i] = n;
        wr(DBASE + 64'(16*i), a, 8);
        wr(DBASE + 64'(16*i + 8), {n, f, l}, 8);
    endtask

    task automatic set_ring(int slot, bit [15:0] v);
        ring[slot] = v;
        wr(ABASE + 64'(4 + 2*slot), 64'(v), 2);
    endtask

    task automatic set_aidx(bit [15:0] v);
        aidx_m = v;
        wr(ABASE + 64'd2, 64'(v), 2);
    endtask

    // Memory responder: latency 1 or 3 cycles depending on address bit 3
    logic        pending = 0;
    logic [63:0] cap;
    int          lat;
    always @(posedge clk) begin
        if (!rst_n) begin
            pending <= 0; mem_rsp_valid <= 0; mem_rsp_data <= '0;
        end else if (mem_rsp_valid) begin
            mem_rsp_valid <= 0; pending <= 0;
        end else if (pending) begin
            if (lat > 0) lat <= lat - 1;
            else begin mem_rsp_valid <= 1; mem_rsp_data <= rd64(cap); end
        end else if (mem_req) begin
            pending <= 1; cap <= mem_addr; lat <= mem_addr[3] ? 2 : 0;
        end
    end

    // Monitor: scoreboard compare on each done
    always @(negedge clk) begin
        if (rst_n && mem_rsp_valid)
            chk(mem_req && mem_addr == cap, "R10 address held", mem_addr, cap);
        if (rst_n && done) begin
            exp_t e;
            if (exp_q.size() == 0) begin
                chk(0, "R8 unexpected done", 64'(done), 64'd0);
            end else begin
                e = exp_q.pop_front();
                chk(empty == e.empty, "R4 empty", 64'(empty), 64'(e.empty));
                chk(err == e.err, "R9 err", 64'(err), 64'(e.err));
                chk(in_cnt == e.in_cnt, "R7 in_cnt", 64'(in_cnt), 64'(e.in_cnt));
                chk(out_cnt == e.out_cnt, "R7 out_cnt", 64'(out_cnt), 64'(e.out_cnt));
                if (!e.empty) chk(head_idx == e.head, "R5 head_idx", 64'(head_idx), 64'(e.head));
                for (int i = 0; i < NS; i++) begin
                    if (i < int'(e.in_cnt)) begin
                        chk(in_addr[i] == e.in_addr[i], "R6 in_addr", in_addr[i], e.in_addr[i]);
                        chk(in_len[i] == e.in_len[i], "R6 in_len", 64'(in_len[i]), 64'(e.in_len[i]));
                    end
                    if (i < int'(e.out_cnt)) begin
                        chk(out_addr[i] == e.out_addr[i], "R6 out_addr", out_addr[i], e.out_addr[i]);
                        chk(out_len[i] == e.out_len[i], "R6 out_len", 64'(out_len[i]), 64'(e.out_len[i]));
                    end
                end
            end
            seen++;
        end
    end

    // Driver: compute expected from the requirements, push, then start
    task automatic fetch();
        exp_t e = '0;
        if (aidx_m == nav) e.empty = 1;
        else begin
            bit [15:0] idx = ring[nav % NS] % NS;
            int total = 0;
            nav++;
            e.head = idx;
            for (int k = 0; k < 16; k++) begin
                if (d_flags[idx][1]) begin
                    e.in_addr[e.in_cnt] = d_addr[idx]; e.in_len[e.in_cnt] = d_len[idx];
                    e.in_cnt++;
                end else begin
                    e.out_addr[e.out_cnt] = d_addr[idx]; e.out_len[e.out_cnt] = d_len[idx];
                    e.out_cnt++;
                end
                total++;
                if (!d_flags[idx][0]) break;
                if (total == NS) begin e.err = 1; break; end
                idx = d_next[idx] % NS;
            end
        end
        exp_q.push_back(e);
        target++;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        while (seen < target) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R8 watchdog", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(done == 0, "R8 reset done", 64'(done), 64'd0);
        chk(mem_req == 0, "R10 reset req", 64'(mem_req), 64'd0);
        chk(in_cnt == 0 && out_cnt == 0, "R7 reset counts", 64'({in_cnt, out_cnt}), 64'd0);

        // R1 R2 R3 address derivation, two sizes
        pfn = 32'd1; qsize_log2 = 4'd8; #1;
        chk(desc_base == 64'h1000, "R1 desc_base", desc_base, 64'h1000);
        chk(avail_base == 64'h2000, "R2 avail_base", avail_base, 64'h2000);
        chk(used_base == 64'h3000, "R3 used_base", used_base, 64'h3000);
        pfn = 32'd5; qsize_log2 = 4'd3; #1;
        chk(avail_base == 64'h5080, "R2 avail_base q8", avail_base, 64'h5080);
        chk(used_base == 64'h6000, "R3 used_base q8", used_base, 64'h6000);
        qsize_log2 = 4'd2; #1;
        chk(desc_base == DBASE, "R1 desc_base q4", desc_base, DBASE);
        chk(avail_base == ABASE, "R2 avail_base q4", avail_base, ABASE);
        chk(used_base == 64'h6000, "R3 used_base q4", used_base, 64'h6000);
        @(negedge clk);

        // R4 empty queue
        set_aidx(16'd0);
        fetch();
        // R5 R6 single device-readable descriptor
        set_desc(0, 64'h0000_1000_0000_0000, 32'd64, 16'h0, 16'h0);
        set_ring(0, 16'd0); set_aidx(16'd1);
        fetch();
        // R7 R8 mixed chain, next index beyond Q masked (7 -> 3)
        set_desc(1, 64'hAAAA_0000_0000_1000, 32'd16, 16'h1, 16'd2);
        set_desc(2, 64'hBBBB_0000_0000_2000, 32'd512, 16'h3, 16'd7);
        set_desc(3, 64'hCCCC_0000_0000_3000, 32'd1, 16'h2, 16'd0);
        set_ring(1, 16'd1); set_aidx(16'd2);
        fetch();
        // R5 head value beyond Q masked (6 -> 2), two writable segments
        set_ring(2, 16'd6); set_aidx(16'd3);
        fetch();
        set_ring(3, 16'd3); set_aidx(16'd4);
        fetch();
        // R4 counter caught up again: empty, no state change
        fetch();
        // R9 wraparound to slot 0 with a self-linked chain
        set_desc(0, 64'hDDDD_0000_0000_4000, 32'd8, 16'h1, 16'd4);
        set_ring(0, 16'd0); set_aidx(16'd5);
        fetch();
        // R4 empty after the error; later post proves the counter advanced once
        fetch();
        set_desc(1, 64'hEEEE_0000_0000_5000, 32'd32, 16'h0, 16'd0);
        set_ring(1, 16'd1); set_aidx(16'd6);
        fetch();

        chk(exp_q.size() == 0, "R8 all results seen", 64'(exp_q.size()), 64'd0);
        summary();
        $finish;
    end
endmodule